// File: doc/BRIEF.md
# Eight-Line Fixed-Priority Interrupt Controller

This block gathers eight interrupt request lines into one interrupt output for a processor. When the processor acknowledges, the block returns an 8-bit vector. The upper five bits of the vector are a programmable base and the lower three bits are the number of the winning line. Line 0 always has the highest priority. The block tracks pending requests, requests in service, and masked lines, each in its own 8-bit register. Bit n of each register belongs to line n.

The processor reaches the block over a small register bus with a one-bit address: 0 is the command port and 1 is the data port. Command-port writes do four things: choose which status register a command-port read returns, send end-of-interrupt, switch between edge and level triggering, and switch data-port writes over to the vector base. Data-port writes normally load the mask, and data-port reads always return the mask.

A request can disappear before the acknowledge arrives. The block still answers in that case, with the line-7 vector, and it marks nothing as in service.

Top module: `pic_top`

## Requirements
- R1: After reset, intOut is low. Data-port reads return 0xFF (all lines masked). Command-port reads return the request register, which is 0x00. The vector base is 0x08.
- R2: In edge mode (the default), a low-to-high change on a line sets its request bit one clock later. The bit stays set only while the line stays high. intOut is high when some unmasked request is pending and no equal-or-higher-priority line is in service.
- R3: A set mask bit stops its own line from raising intOut or winning an acknowledge. Its request bit is still recorded. Masking one line never changes how other lines are treated, including lower-numbered lines.
- R4: Priority is fixed with line 0 highest. The vector is {base[4:0], line[2:0]}. It appears on vecOut at the clock edge that samples intAck and holds until the next acknowledge.
- R5: At an acknowledged edge, the winning request bit moves into the in-service register. intOut is low during every cycle in which intAck is high.
- R6: Writing 0x20 to the command port clears the lowest-numbered set bit of the in-service register.
- R7: Writing 0x0A to the command port makes command-port reads return the request register. Writing 0x0B makes them return the in-service register. The choice persists across any number of reads.
- R8: An acknowledge with no unmasked, unblocked request gives vector {base, 3'b111} and sets no in-service bit.
- R9: A command-port write of the form 0x1X sets level mode from bit 0. In level mode, a request bit follows its line: set while the line is high, clear once it is low.
- R10: Bit 1 of the same 0x1X command makes data-port writes load the base from data bits [7:3] and leave the mask unchanged.
- R11: A higher-priority request that arrives while a lower line is in service raises intOut again (nesting).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| irqLines | input | 8 | Interrupt request lines, line 0 highest priority |
| busAddr | input | 1 | Port select: 0 command, 1 data |
| busWrEn | input | 1 | Register write strobe |
| busWrData | input | 8 | Register write data |
| busRdData | output | 8 | Read data for the port selected by busAddr |
| intOut | output | 1 | Interrupt request to the processor |
| intAck | input | 1 | Interrupt acknowledge, one cycle per acknowledge |
| vecOut | output | 8 | Vector from the latest acknowledge |

## Verification
A line change shows in the request register, in intOut and in command-port reads one clock after the edge that samples it. An acknowledge or an end-of-interrupt changes vecOut and the in-service register at the edge that samples it, while intOut falls during the acknowledge cycle itself. Register writes take effect on busRdData and on later behaviour starting in the next cycle. The bench advances its model at every rising edge using the same sampled inputs, then compares intOut, vecOut and busRdData at the following falling edge. At that point every one-cycle result is already due and no input has changed yet.

// File: rtl/pic_pkg.sv
package pic_pkg;
  localparam logic [7:0] CMD_SEL_REQ = 8'h0A;
  localparam logic [7:0] CMD_SEL_SVC = 8'h0B;
  localparam logic [7:0] CMD_EOI     = 8'h20;
  localparam logic [3:0] CMD_CFG_HI  = 4'h1;

  typedef struct packed {
    logic eoi;
    logic ack;
    logic maskWr;
    logic baseWr;
    logic levelMode;
    logic readSvc;
  } picCtl_t;
endpackage

// File: rtl/pic_prio.sv
module pic_prio #(
  parameter int N = 8,
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]     reqVec,
  output logic             anySet,
  output logic [IDX_W-1:0] lowIdx
);
  always_comb begin
    anySet = |reqVec;
    lowIdx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (reqVec[i]) lowIdx = IDX_W'(i);
    end
  end
endmodule

// File: rtl/pic_ctrl.sv
module pic_ctrl
  import pic_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busAddr,
  input  logic              busWrEn,
  input  logic [DATA_W-1:0] busWrData,
  input  logic              intAck,
  output picCtl_t           ctl
);
  logic levelQ, baseModeQ, readSvcQ;
  logic cmdWr, dataWr;

  assign cmdWr  = busWrEn & ~busAddr;
  assign dataWr = busWrEn & busAddr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      levelQ    <= 1'b0;
      baseModeQ <= 1'b0;
      readSvcQ  <= 1'b0;
    end else if (cmdWr) begin
      if (busWrData[7:0] == CMD_SEL_REQ) readSvcQ <= 1'b0;
      if (busWrData[7:0] == CMD_SEL_SVC) readSvcQ <= 1'b1;
      if (busWrData[7:4] == CMD_CFG_HI) begin
        levelQ    <= busWrData[0];
        baseModeQ <= busWrData[1];
      end
    end
  end

  always_comb begin
    ctl.eoi       = cmdWr && (busWrData[7:0] == CMD_EOI);
    ctl.ack       = intAck;
    ctl.maskWr    = dataWr & ~baseModeQ;
    ctl.baseWr    = dataWr & baseModeQ;
    ctl.levelMode = levelQ;
    ctl.readSvc   = readSvcQ;
  end
endmodule

// File: rtl/pic_datapath.sv
module pic_datapath
  import pic_pkg::*;
#(
  parameter int NUM_LINES = 8,
  parameter int DATA_W = 8,
  parameter logic [7:0] RESET_VEC = 8'h08,
  localparam int IDX_W = $clog2(NUM_LINES),
  localparam int BASE_W = DATA_W - IDX_W
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_LINES-1:0] irqLines,
  input  logic                 busAddr,
  input  logic [DATA_W-1:0]    busWrData,
  input  picCtl_t              ctl,
  output logic                 intReq,
  output logic [DATA_W-1:0]    vecOut,
  output logic [DATA_W-1:0]    rdData,
  output logic [NUM_LINES-1:0] irrQ,
  output logic [NUM_LINES-1:0] isrQ,
  output logic [NUM_LINES-1:0] maskQ
);
  logic [NUM_LINES-1:0] lineQ, irrNext, pending, takeBit, eoiBit;
  logic [BASE_W-1:0]    baseQ;
  logic [IDX_W-1:0]     reqIdx, svcIdx;
  logic                 reqAny, svcAny, grant;

  for (genvar n = 0; n < NUM_LINES; n++) begin : g_line
    always_comb begin
      if (ctl.levelMode) irrNext[n] = irqLines[n];
      else irrNext[n] = irqLines[n] & (~lineQ[n] | irrQ[n]);
    end
  end

  assign pending = irrQ & ~maskQ;

  pic_prio #(.N(NUM_LINES)) u_reqPrio (.reqVec(pending), .anySet(reqAny), .lowIdx(reqIdx));
  pic_prio #(.N(NUM_LINES)) u_svcPrio (.reqVec(isrQ), .anySet(svcAny), .lowIdx(svcIdx));

  assign grant   = reqAny && (!svcAny || (reqIdx < svcIdx));
  assign intReq  = grant;
  assign takeBit = (ctl.ack && grant) ? (NUM_LINES'(1) << reqIdx) : '0;
  assign eoiBit  = (ctl.eoi && svcAny) ? (NUM_LINES'(1) << svcIdx) : '0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lineQ  <= '0;
      irrQ   <= '0;
      isrQ   <= '0;
      maskQ  <= '1;
      baseQ  <= RESET_VEC[DATA_W-1:IDX_W];
      vecOut <= '0;
    end else begin
      lineQ <= irqLines;
      irrQ  <= irrNext & ~takeBit;
      isrQ  <= (isrQ & ~eoiBit) | takeBit;
      if (ctl.maskWr) maskQ <= busWrData[NUM_LINES-1:0];
      if (ctl.baseWr) baseQ <= busWrData[DATA_W-1:IDX_W];
      if (ctl.ack) vecOut <= {baseQ, grant ? reqIdx : {IDX_W{1'b1}}};
    end
  end

  always_comb begin
    if (busAddr) rdData = DATA_W'(maskQ);
    else if (ctl.readSvc) rdData = DATA_W'(isrQ);
    else rdData = DATA_W'(irrQ);
  end
endmodule

// File: rtl/pic_top.sv
module pic_top
  import pic_pkg::*;
#(
  parameter int NUM_LINES = 8,
  parameter int DATA_W = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_LINES-1:0] irqLines,
  input  logic                 busAddr,
  input  logic                 busWrEn,
  input  logic [DATA_W-1:0]    busWrData,
  output logic [DATA_W-1:0]    busRdData,
  output logic                 intOut,
  input  logic                 intAck,
  output logic [DATA_W-1:0]    vecOut
);
  picCtl_t              ctl;
  logic                 intReq;
  logic [NUM_LINES-1:0] irrQ, isrQ, maskQ;

  pic_ctrl #(.DATA_W(DATA_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
    .busWrData(busWrData), .intAck(intAck), .ctl(ctl)
  );

  pic_datapath #(.NUM_LINES(NUM_LINES), .DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .irqLines(irqLines), .busAddr(busAddr),
    .busWrData(busWrData), .ctl(ctl), .intReq(intReq), .vecOut(vecOut),
    .rdData(busRdData), .irrQ(irrQ), .isrQ(isrQ), .maskQ(maskQ)
  );

  assign intOut = intReq & ~intAck;
endmodule

// File: rtl/pic_checker.sv
module pic_checker #(
  parameter int NUM_LINES = 8,
  parameter int DATA_W = 8,
  localparam int IDX_W = $clog2(NUM_LINES)
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 intAck,
  input logic                 intOut,
  input logic                 busAddr,
  input logic                 busWrEn,
  input logic [DATA_W-1:0]    busWrData,
  input logic [DATA_W-1:0]    vecOut,
  input logic [NUM_LINES-1:0] irrQ,
  input logic [NUM_LINES-1:0] isrQ,
  input logic [NUM_LINES-1:0] maskQ
);
  logic eoiCmd;
  assign eoiCmd = busWrEn && !busAddr && (busWrData[7:0] == 8'h20);

  // R2: the interrupt output needs an unmasked pending request behind it
  a_r2_int_has_source: assert property (@(posedge clk) disable iff (!rstN)
    intOut |-> ((irrQ & ~maskQ) != '0));

  // R3: an acknowledge never puts a masked line in service
  a_r3_masked_never_taken: assert property (@(posedge clk) disable iff (!rstN)
    intAck |=> ((isrQ & ~$past(isrQ) & $past(maskQ)) == '0));

  // R5: one acknowledge adds at most one in-service bit
  a_r5_single_grant: assert property (@(posedge clk) disable iff (!rstN)
    (intAck && !eoiCmd) |=> ($countones(isrQ) <= $past($countones(isrQ)) + 1));

  // R6: end-of-interrupt removes exactly one in-service bit
  a_r6_eoi_drops_one: assert property (@(posedge clk) disable iff (!rstN)
    (eoiCmd && !intAck && (isrQ != '0)) |=> ($countones(isrQ) == $past($countones(isrQ)) - 1));

  // R8: with nothing eligible, the acknowledge yields the line-7 vector and leaves service untouched
  a_r8_spurious_vector: assert property (@(posedge clk) disable iff (!rstN)
    (intAck && ((irrQ & ~maskQ) == '0) && !eoiCmd)
      |=> ((vecOut[IDX_W-1:0] == {IDX_W{1'b1}}) && (isrQ == $past(isrQ))));
endmodule

bind pic_top pic_checker #(.NUM_LINES(NUM_LINES), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rstN(rstN), .intAck(intAck), .intOut(intOut), .busAddr(busAddr),
  .busWrEn(busWrEn), .busWrData(busWrData), .vecOut(vecOut),
  .irrQ(irrQ), .isrQ(isrQ), .maskQ(maskQ)
);

// File: tb/sim_pic_top.sv
module sim_pic_top;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [7:0] irqLines = '0;
  logic       busAddr = 1'b0;
  logic       busWrEn = 1'b0;
  logic [7:0] busWrData = '0;
  logic [7:0] busRdData;
  logic       intOut;
  logic       intAck = 1'b0;
  logic [7:0] vecOut;

  int testsRun = 0;
  int testsFailed = 0;
  bit finished = 0;

  // behavioural reference state
  logic [7:0] mReq, mSvc, mMask, mPrev, mVec;
  logic [4:0] mBase;
  bit mLevel, mBaseMode, mSelSvc;

  pic_top u0 (
    .clk(clk), .rstN(rstN), .irqLines(irqLines), .busAddr(busAddr),
    .busWrEn(busWrEn), .busWrData(busWrData), .busRdData(busRdData),
    .intOut(intOut), .intAck(intAck), .vecOut(vecOut)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  function automatic int firstBit(logic [7:0] v);
    int k = 8;
    while (k > 0 && v[k-1] == 1'b0 || (k > 0 && ((v & ((8'h1 << (k - 1)) - 8'h1)) != 0))) k--;
    return (v == 0) ? 8 : k - 1;
  endfunction

  function automatic bit expInt();
    int r = firstBit(mReq & ~mMask);
    int s = firstBit(mSvc);
    return (r < 8) && (r < s) && !intAck;
  endfunction

  function automatic logic [7:0] expRead();
    if (busAddr) return mMask;
    return mSelSvc ? mSvc : mReq;
  endfunction

  task automatic modelStep();
    int r, s;
    bit gr;
    logic [7:0] nReq, nSvc;
    if (!rstN) begin
      mReq = 0; mSvc = 0; mMask = 8'hFF; mPrev = 0; mVec = 0; mBase = 5'd1;
      mLevel = 0; mBaseMode = 0; mSelSvc = 0;
      return;
    end
    r = firstBit(mReq & ~mMask);
    s = firstBit(mSvc);
    gr = (r < 8) && (r < s);
    for (int i = 0; i < 8; i++)
      nReq[i] = mLevel ? irqLines[i] : (irqLines[i] && (!mPrev[i] || mReq[i]));
    nSvc = mSvc;
    if (busWrEn && !busAddr && busWrData == 8'h20 && s < 8) nSvc[s] = 1'b0;
    if (intAck) begin
      mVec = {mBase, gr ? 3'(r) : 3'd7};
      if (gr) begin nReq[r] = 1'b0; nSvc[r] = 1'b1; end
    end
    if (busWrEn && !busAddr) begin
      if (busWrData == 8'h0A) mSelSvc = 0;
      if (busWrData == 8'h0B) mSelSvc = 1;
      if (busWrData[7:4] == 4'h1) begin mLevel = busWrData[0]; mBaseMode = busWrData[1]; end
    end
    if (busWrEn && busAddr) begin
      if (mBaseMode) mBase = busWrData[7:3];
      else mMask = busWrData;
    end
    mPrev = irqLines;
    mReq = nReq;
    mSvc = nSvc;
  endtask

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    testsRun++;
    if (act !== exp) begin
      testsFailed++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    modelStep();
    @(negedge clk);
    chk("R2 intOut per-cycle", {7'b0, intOut}, {7'b0, expInt()});
    chk("R4 vecOut per-cycle", vecOut, mVec);
    chk("R7 busRdData per-cycle", busRdData, expRead());
  endtask

  task automatic wrCmd(logic [7:0] d);
    busAddr = 0; busWrData = d; busWrEn = 1; tick(); busWrEn = 0;
  endtask

  task automatic wrDat(logic [7:0] d);
    busAddr = 1; busWrData = d; busWrEn = 1; tick(); busWrEn = 0; busAddr = 0;
  endtask

  task automatic doAck();
    intAck = 1; tick(); intAck = 0;
  endtask

  initial begin
    repeat (3) tick();
    rstN = 1;
    tick();
    // R1 reset state
    chk("R1 intOut", {7'b0, intOut}, 8'h00);
    busAddr = 1; #1; chk("R1 mask", busRdData, 8'hFF);
    busAddr = 0; #1; chk("R1 request", busRdData, 8'h00);
    doAck(); chk("R1 base spurious vector", vecOut, 8'h0F);

    wrDat(8'h20);
    irqLines[3] = 1; tick();
    chk("R2 edge raises intOut", {7'b0, intOut}, 8'h01);
    chk("R7 request read", busRdData, 8'h08);
    irqLines[5] = 1; tick();
    chk("R3 masked recorded", busRdData, 8'h28);
    doAck();
    chk("R4 vector line3", vecOut, 8'h0B);
    chk("R5 intOut idle after ack", {7'b0, intOut}, 8'h00);
    wrCmd(8'h0B);
    chk("R7 service read", busRdData, 8'h08);
    tick(); tick();
    chk("R7 selection persists", busRdData, 8'h08);

    irqLines[1] = 1; tick();
    chk("R11 nesting raises intOut", {7'b0, intOut}, 8'h01);
    doAck();
    chk("R4 vector line1", vecOut, 8'h09);
    chk("R5 service gained", busRdData, 8'h0A);
    wrCmd(8'h20); chk("R6 eoi clears line1", busRdData, 8'h08);
    wrCmd(8'h20); chk("R6 eoi clears line3", busRdData, 8'h00);
    irqLines = 0; tick();

    irqLines[6] = 1; tick();
    chk("R8 pending before drop", {7'b0, intOut}, 8'h01);
    irqLines[6] = 0; tick();
    doAck();
    chk("R8 spurious vector", vecOut, 8'h0F);
    chk("R8 no service bit", busRdData, 8'h00);

    wrCmd(8'h11); wrCmd(8'h0A);
    irqLines[2] = 1; tick();
    chk("R9 level request", busRdData, 8'h04);
    doAck(); chk("R4 vector line2", vecOut, 8'h0A);
    tick(); chk("R9 level reasserts", busRdData, 8'h04);
    chk("R5 blocked by own service", {7'b0, intOut}, 8'h00);
    wrCmd(8'h20);
    chk("R9 level retriggers", {7'b0, intOut}, 8'h01);
    irqLines[2] = 0; tick();
    chk("R9 level drop clears", busRdData, 8'h00);

    wrCmd(8'h12); wrDat(8'hA8);
    busAddr = 1; #1; chk("R10 mask kept", busRdData, 8'h20); busAddr = 0;
    wrCmd(8'h10);
    irqLines[4] = 1; tick();
    doAck(); chk("R10 new base vector", vecOut, 8'hAC);
    wrCmd(8'h20); irqLines = 0; tick();

    wrDat(8'h01);
    irqLines[0] = 1; irqLines[6] = 1; tick();
    doAck(); chk("R3 masked line0 skipped", vecOut, 8'hAE);
    wrCmd(8'h20); irqLines = 0; tick(); tick();

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      testsRun++; testsFailed++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end
endmodule